// File: doc/BRIEF.md
# Write Block Narrowing Clock-Crossing FIFO

This block takes blocks of wide data words from a producer in the user clock domain and hands them out as 72-bit words in a separate memory clock domain. Each stored wide word is split into two pieces (144-bit configuration) or four pieces (288-bit configuration). The consumer pops one piece per read strobe, and the pieces come out least significant first. Storage is a dual-clock register array. The write and read pointers pass between the domains as gray code through two-flop synchronisers.

On the user side, data is taken on cycles where the valid strobe is high. The full flag is raised one entry early. This gives the producer one cycle to react: the word it presents in the same cycle that full goes high is still stored. The block counts accepted words against a fixed block length (113 words at 144 bits, 56 words at 288 bits). It raises the done flag together with the word that closes a block, and the next accepted word starts a new block. On the memory side, the empty flag is computed in the memory clock domain, and a pop while empty is ignored.

Top module: `wbn_narrow_fifo`

## Requirements
- R1: While reset is asserted and right after it, `u_full_o` and `u_done_o` are 0 and `m_empty_o` is 1.
- R2: A wide word is emitted as USER_W/72 pieces (2 for 144 bits, 4 for 288 bits). Piece k is bits [72k+71:72k], and piece 0 comes out first.
- R3: Pieces of all accepted words appear on `m_data_o` in acceptance order, with none lost and none repeated.
- R4: A word is stored only on a `uclk_i` edge where `u_vld_i` is 1. While `u_vld_i` is low, `u_data_i` has no effect and `m_empty_o` stays 1 on an empty FIFO.
- R5: `u_full_o` rises when DEPTH-1 entries are occupied. One word presented in the cycle `u_full_o` is first high is still stored, so DEPTH words fit in total.
- R6: `u_done_o` is 1 exactly in the cycle where the accepted word is the last of a block (word 113 at 144 bits, word 56 at 288 bits). It is 0 in all other cycles, and the count restarts with the next word.
- R7: `m_empty_o` is 1 when no unread piece remains. A pop while empty does not move the read position.
- R8: The pointers crossing domains change by at most one bit per edge of their own clock.
- R9: After the consumer drains the FIFO, `u_full_o` falls and `m_empty_o` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| uclk_i | input | 1 | User-side clock |
| mclk_i | input | 1 | Memory-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| u_vld_i | input | 1 | Wide data word valid |
| u_data_i | input | USER_W | Wide data word |
| u_full_o | output | 1 | Stop presenting data from the next cycle |
| u_done_o | output | 1 | Current accepted word closes the block |
| m_rd_i | input | 1 | Pop one 72-bit piece |
| m_data_o | output | 72 | Piece at the head of the FIFO |
| m_empty_o | output | 1 | No piece available |

## Verification
The hardest state to reach is the one-word slack. The FIFO must hold exactly DEPTH-1 words while the synchronised read pointer is fully settled, and a word must be presented in the very cycle full rises. The bench gets there by stalling the consumer, letting the pointers settle, writing until full, and then pushing one extra word. It then checks that every piece drains in order. Pops on an empty FIFO are driven before the first write to show that the read position does not move. A long run with random valid and pop densities crosses several block boundaries, and done is checked on each one.

// File: rtl/wbn_pkg.sv
package wbn_pkg;
  localparam int MEM_W = 72;

  function automatic int blk_words(input int user_w);
    return (user_w == 288) ? 56 : 113;
  endfunction
endpackage

// File: rtl/wbn_ptr_sync.sv
// two-flop gray synchroniser with binary decode in the destination domain
module wbn_ptr_sync #(
  parameter int PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);
  logic [PW-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    bin_o[PW-1] = s2_q[PW-1];
    for (int i = PW-2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ s2_q[i];
  end
endmodule

// File: rtl/wbn_dpram.sv
module wbn_dpram #(
  parameter int DW = 144,
  parameter int AW = 3
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/wbn_wr_ctrl.sv
module wbn_wr_ctrl #(
  parameter int AW        = 3,
  parameter int BLK_WORDS = 113
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        vld_i,
  input  logic [AW:0] rptr_bin_i,
  output logic        we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0] wptr_gray_o,
  output logic        full_o,
  output logic        done_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(BLK_WORDS);

  logic [PW-1:0] wbin_q, wbin_nxt, used;
  logic [CW-1:0] cnt_q;
  logic          last_word;

  assign used      = wbin_q - rptr_bin_i;
  assign we_o      = vld_i && (used != PW'(DEPTH));
  // early flag: one free entry remains for the word presented while it rises
  assign full_o    = used >= PW'(DEPTH - 1);
  assign last_word = cnt_q == CW'(BLK_WORDS - 1);
  assign done_o    = we_o && last_word;
  assign wbin_nxt  = wbin_q + PW'(we_o);
  assign waddr_o   = wbin_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q      <= '0;
      wptr_gray_o <= '0;
      cnt_q       <= '0;
    end else begin
      wbin_q      <= wbin_nxt;
      wptr_gray_o <= wbin_nxt ^ (wbin_nxt >> 1);
      if (we_o) cnt_q <= last_word ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/wbn_rd_ctrl.sv
module wbn_rd_ctrl #(
  parameter int AW    = 3,
  parameter int RATIO = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [AW:0]   wptr_bin_i,
  output logic [AW-1:0] raddr_o,
  output logic [$clog2(RATIO)-1:0] sel_o,
  output logic [AW:0]   rptr_gray_o,
  output logic          empty_o
);
  localparam int PW = AW + 1;
  localparam int SW = $clog2(RATIO);

  logic [PW-1:0] rbin_q, rbin_nxt;
  logic          pop, last_piece;

  assign empty_o    = rbin_q == wptr_bin_i;
  assign pop        = rd_i && !empty_o;
  assign last_piece = sel_o == SW'(RATIO - 1);
  assign rbin_nxt   = rbin_q + PW'(pop && last_piece);
  assign raddr_o    = rbin_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q      <= '0;
      rptr_gray_o <= '0;
      sel_o       <= '0;
    end else begin
      rbin_q      <= rbin_nxt;
      rptr_gray_o <= rbin_nxt ^ (rbin_nxt >> 1);
      if (pop) sel_o <= last_piece ? '0 : sel_o + SW'(1);
    end
  end
endmodule

// File: rtl/wbn_narrow_fifo.sv
module wbn_narrow_fifo #(
  parameter int USER_W     = 144,
  parameter int DEPTH_LOG2 = 3
) (
  input  logic              uclk_i,
  input  logic              mclk_i,
  input  logic              rst_ni,
  input  logic              u_vld_i,
  input  logic [USER_W-1:0] u_data_i,
  output logic              u_full_o,
  output logic              u_done_o,
  input  logic              m_rd_i,
  output logic [71:0]       m_data_o,
  output logic              m_empty_o
);
  import wbn_pkg::*;
  localparam int AW    = DEPTH_LOG2;
  localparam int PW    = AW + 1;
  localparam int RATIO = USER_W / MEM_W;
  localparam int SW    = $clog2(RATIO);
  localparam int BLKW  = blk_words(USER_W);

  logic              we;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, rgray, rsync_bin, wsync_bin;
  logic [SW-1:0]     sel;
  logic [USER_W-1:0] rdata;

  wbn_wr_ctrl #(.AW(AW), .BLK_WORDS(BLKW)) u_wr (
    .clk_i(uclk_i), .rst_ni(rst_ni), .vld_i(u_vld_i), .rptr_bin_i(rsync_bin),
    .we_o(we), .waddr_o(waddr), .wptr_gray_o(wgray),
    .full_o(u_full_o), .done_o(u_done_o)
  );

  wbn_ptr_sync #(.PW(PW)) u_r2w (
    .clk_i(uclk_i), .rst_ni(rst_ni), .gray_i(rgray), .bin_o(rsync_bin)
  );

  wbn_ptr_sync #(.PW(PW)) u_w2r (
    .clk_i(mclk_i), .rst_ni(rst_ni), .gray_i(wgray), .bin_o(wsync_bin)
  );

  wbn_dpram #(.DW(USER_W), .AW(AW)) u_mem (
    .wclk_i(uclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(u_data_i),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  wbn_rd_ctrl #(.AW(AW), .RATIO(RATIO)) u_rd (
    .clk_i(mclk_i), .rst_ni(rst_ni), .rd_i(m_rd_i), .wptr_bin_i(wsync_bin),
    .raddr_o(raddr), .sel_o(sel), .rptr_gray_o(rgray), .empty_o(m_empty_o)
  );

  // piece select, least significant piece first
  always_comb begin
    m_data_o = '0;
    for (int k = 0; k < RATIO; k++)
      if (sel == SW'(k)) m_data_o = rdata[k*MEM_W +: MEM_W];
  end
endmodule

// File: rtl/wbn_narrow_fifo_chk.sv
module wbn_narrow_fifo_chk #(
  parameter int PW = 4
) (
  input logic          uclk_i,
  input logic          mclk_i,
  input logic          rst_ni,
  input logic          u_vld_i,
  input logic          u_full_o,
  input logic          u_done_o,
  input logic          m_empty_o,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic [PW-1:0] rsync_bin
);
  localparam int DEPTH = 1 << (PW - 1);
  logic [PW-1:0] wbin, used;

  always_comb begin
    wbin[PW-1] = wgray[PW-1];
    for (int i = PW-2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray[i];
  end
  assign used = wbin - rsync_bin;

  a_r1_reset_flags: assert property (@(posedge uclk_i)
    $rose(rst_ni) |-> !u_full_o && !u_done_o);
  a_r5_no_overflow: assert property (@(posedge uclk_i) disable iff (!rst_ni)
    used <= PW'(DEPTH));
  a_r5_full_rise_slack: assert property (@(posedge uclk_i) disable iff (!rst_ni)
    $rose(u_full_o) |-> used == PW'(DEPTH - 1));
  a_r6_done_with_vld: assert property (@(posedge uclk_i) disable iff (!rst_ni)
    u_done_o |-> u_vld_i);
  a_r6_done_single: assert property (@(posedge uclk_i) disable iff (!rst_ni)
    u_done_o |=> !u_done_o);
  a_r7_empty_no_move: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    m_empty_o |=> $stable(rgray));
  a_r8_wgray_step: assert property (@(posedge uclk_i) disable iff (!rst_ni)
    $onehot0(wgray ^ $past(wgray)));
  a_r8_rgray_step: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    $onehot0(rgray ^ $past(rgray)));
endmodule

bind wbn_narrow_fifo wbn_narrow_fifo_chk #(.PW(DEPTH_LOG2 + 1)) u_chk (
  .uclk_i(uclk_i), .mclk_i(mclk_i), .rst_ni(rst_ni), .u_vld_i(u_vld_i),
  .u_full_o(u_full_o), .u_done_o(u_done_o), .m_empty_o(m_empty_o),
  .wgray(wgray), .rgray(rgray), .rsync_bin(rsync_bin)
);

// File: tb/tb_wbn_narrow_fifo.sv
module tb_wbn_narrow_fifo;
  localparam int USER_W = 144;
  localparam int DL2    = 3;
  localparam int DEPTH  = 1 << DL2;
  localparam int RATIO  = USER_W / 72;
  localparam int BLK    = (USER_W == 288) ? 56 : 113;

  logic uclk = 0, mclk = 0, rst_ni = 0;
  logic u_vld = 0, m_rd = 0;
  logic [USER_W-1:0] u_data = '0;
  logic u_full, u_done, m_empty;
  logic [71:0] m_data;

  always #10 uclk = ~uclk;
  always #7  mclk = ~mclk;

  wbn_narrow_fifo #(.USER_W(USER_W), .DEPTH_LOG2(DL2)) dut (
    .uclk_i(uclk), .mclk_i(mclk), .rst_ni(rst_ni), .u_vld_i(u_vld),
    .u_data_i(u_data), .u_full_o(u_full), .u_done_o(u_done),
    .m_rd_i(m_rd), .m_data_o(m_data), .m_empty_o(m_empty)
  );

  int n_cmp = 0, n_bad = 0, widx = 0;
  logic [71:0] expq[$];
  bit rd_en = 0, rd_rand = 0, ghost = 0;

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [USER_W-1:0] rand_word();
    logic [USER_W-1:0] w = '0;
    for (int k = 0; k < (USER_W + 31) / 32; k++) w = (w << 32) | USER_W'($urandom());
    return w;
  endfunction

  // called at a negedge of uclk; returns at the following negedge
  task automatic put_word(input logic [USER_W-1:0] w);
    bit exp_done;
    for (int k = 0; k < RATIO; k++) expq.push_back(w[k*72 +: 72]); // R2 piece order
    exp_done = (widx % BLK) == BLK - 1;
    widx++;
    u_vld = 1; u_data = w;
    #1 chk(u_done == exp_done, "R6 done on block end", 72'(u_done), 72'(exp_done));
    @(negedge uclk);
    u_vld = 0;
  endtask

  // consumer
  initial begin
    forever begin
      @(negedge mclk);
      m_rd = 0;
      if (ghost) m_rd = 1;
      else if (rd_en && !m_empty && (!rd_rand || $urandom_range(9) < 6)) begin
        m_rd = 1;
        #1;
        if (expq.size() == 0) chk(0, "R3 unexpected piece", m_data, 72'h0);
        else begin
          chk(m_data == expq[0], "R3 piece order", m_data, expq[0]);
          void'(expq.pop_front());
        end
      end
    end
  end

  task automatic drain();
    int t = 0;
    while (expq.size() != 0 && t < 20000) begin @(negedge uclk); t++; end
    repeat (10) @(negedge uclk);
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd4711));
    #35;
    chk(!u_full && !u_done && m_empty, "R1 reset flags", {u_full, u_done, m_empty}, 72'b001);
    @(negedge uclk); rst_ni = 1;
    @(negedge uclk);
    chk(!u_full && !u_done && m_empty, "R1 after reset", {u_full, u_done, m_empty}, 72'b001);

    // R4: data toggling without valid stores nothing
    repeat (20) begin u_data = rand_word(); @(negedge uclk); end
    repeat (6) @(negedge uclk);
    chk(m_empty == 1, "R4 no store without valid", 72'(m_empty), 72'd1);

    // R7: pops on empty are ignored
    ghost = 1;
    repeat (6) @(negedge mclk);
    ghost = 0;
    @(negedge uclk);
    put_word(rand_word());
    rd_en = 1;
    drain();
    chk(expq.size() == 0, "R7 first piece after empty pops", 72'(expq.size()), 72'd0);

    // R5: fill to the early flag, then one slack word
    rd_en = 0;
    repeat (10) @(negedge uclk);
    cnt = 0;
    while (!u_full && cnt < 2 * DEPTH) begin put_word(rand_word()); cnt++; end
    chk(cnt == DEPTH - 1, "R5 full rises at DEPTH-1", 72'(cnt), 72'(DEPTH - 1));
    put_word(rand_word());
    repeat (10) @(negedge uclk);
    chk(u_full == 1, "R5 full held while stalled", 72'(u_full), 72'd1);
    rd_en = 1;
    drain();
    chk(expq.size() == 0, "R5 slack word delivered", 72'(expq.size()), 72'd0);
    chk(!u_full && m_empty, "R9 flags after drain", {u_full, m_empty}, 72'b01);

    // random traffic across several block boundaries
    rd_rand = 1;
    for (int i = 0; i < 3 * BLK; i++) begin
      while (u_full || $urandom_range(9) > 6) begin
        @(negedge uclk);
      end
      put_word(rand_word());
    end
    chk(u_done == 0, "R6 done low when idle", 72'(u_done), 72'd0);
    drain();
    chk(expq.size() == 0, "R3 all pieces delivered", 72'(expq.size()), 72'd0);
    chk(!u_full && m_empty, "R9 flags after random drain", {u_full, m_empty}, 72'b01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #3_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 72'd0, 72'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule